// File: doc/BRIEF.md
# Conditional Branch and Skip Next-PC Unit

This block works out where program flow goes after a conditional flow-control instruction, and how many cycles that instruction costs. It covers two families. Relative branches test one status-register bit. The bit is either picked by an index or fixed by the branch flavour: signed greater-or-equal and less-than, or unsigned same-or-higher and lower. Skips compare two bytes for equality, or test one bit of a supplied register or I/O byte. A taken skip steps over the instruction that follows it, and the length of that instruction sets both the PC step and the cycle cost.

The decoder presents the current PC, the status byte, a 4-bit operation code, a signed relative offset, a bit index, the byte under test, the byte to compare against, and a flag that says whether the following instruction occupies two words. Every clock edge, the block registers three results together: the next PC, a taken flag and the cycle count. PC arithmetic wraps modulo 2^PC_W.

Top module: `flow_next_pc`

## Requirements
- R1: While reset is held (active low), next PC, taken flag and cycle count are all zero.
- R2: Operation code 0 branches when `status[bit_sel]` is 1. Operation code 1 branches when `status[bit_sel]` is 0.
- R3: Operation code 2 (signed greater-or-equal) branches when status bit 2 XOR status bit 3 is 0. Operation code 3 (signed less-than) branches when that XOR is 1. Bit 2 is the negative flag and bit 3 is the overflow flag.
- R4: Operation code 4 (same-or-higher) branches when status bit 0, the carry flag, is 0. Operation code 5 (lower) branches when it is 1.
- R5: A taken branch gives next PC = PC + sign-extended offset + 1 and costs 2 cycles. An untaken branch gives PC + 1 and costs 1 cycle. Both wrap modulo 2^PC_W.
- R6: Operation code 6 skips when the test byte equals the compare byte.
- R7: Operation code 7 skips when `test_byte[bit_sel]` is 0. Operation code 8 skips when it is 1.
- R8: A taken skip gives PC + 2 and costs 2 cycles when the next instruction is one word, and gives PC + 3 and costs 3 cycles when it is two words. An untaken skip gives PC + 1 and costs 1 cycle.
- R9: Operation codes 9 to 15 give PC + 1, cost 1 cycle and are never taken, whatever the status and offset inputs hold.
- R10: All three outputs update together, one clock edge after the inputs are presented, and hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | PC_W | PC of the flow-control instruction |
| status | input | 8 | Status byte (C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7) |
| op_kind | input | 4 | Operation code, 0 to 8 defined |
| rel_off | input | OFF_W | Two's-complement relative branch offset |
| bit_sel | input | 3 | Bit index for generic branch and bit skips |
| test_byte | input | 8 | Register or I/O byte under test |
| cmp_byte | input | 8 | Second operand for skip-if-equal |
| next_two_word | input | 1 | Following instruction is two words long |
| nxt_pc | output | PC_W | Registered next PC |
| taken | output | 1 | Registered branch-taken or skip-taken flag |
| cycles | output | 2 | Registered cycle count (1 to 3) |

## Verification
The bench builds the block with PC_W = 12 and the default 7-bit offset. This makes wrap-around of both relative targets and skip steps reachable from random and directed PCs. It sweeps all 16 operation codes against all 256 status bytes and all 8 bit indices. The test and compare bytes are derived from the status value, so that equality and both bit polarities each occur many times. Directed vectors drive the PC across the top and bottom of the 12-bit range with extreme offsets and two-word skips, and one vector confirms that the outputs hold until the next edge.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

  // operation codes presented by the decoder
  localparam logic [3:0] OP_BR_BSET = 4'd0;
  localparam logic [3:0] OP_BR_BCLR = 4'd1;
  localparam logic [3:0] OP_BR_SGE  = 4'd2;
  localparam logic [3:0] OP_BR_SLT  = 4'd3;
  localparam logic [3:0] OP_BR_USH  = 4'd4;
  localparam logic [3:0] OP_BR_ULO  = 4'd5;
  localparam logic [3:0] OP_SK_EQ   = 4'd6;
  localparam logic [3:0] OP_SK_BCLR = 4'd7;
  localparam logic [3:0] OP_SK_BSET = 4'd8;

  // status byte positions used by fixed-condition branches
  localparam int ST_CARRY = 0;
  localparam int ST_NEG   = 2;
  localparam int ST_OVF   = 3;

  typedef enum logic [1:0] {
    NX_SEQ   = 2'd0,
    NX_REL   = 2'd1,
    NX_SKIP1 = 2'd2,
    NX_SKIP2 = 2'd3
  } next_sel_e;

  // signed "less than" as seen by the negative and overflow flags
  function automatic logic signed_lt(input logic [7:0] st);
    return st[ST_NEG] ^ st[ST_OVF];
  endfunction

  // step size for the non-relative next-PC choices
  function automatic logic [1:0] seq_step(input next_sel_e s);
    case (s)
      NX_SKIP1: return 2'd2;
      NX_SKIP2: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

  // cycles spent by the instruction for each next-PC choice
  function automatic logic [1:0] cost_of(input next_sel_e s);
    case (s)
      NX_REL:   return 2'd2;
      NX_SKIP1: return 2'd2;
      NX_SKIP2: return 2'd3;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flowctl_pkg::*;
(
  input  logic [3:0] op_kind,
  input  logic [7:0] status,
  input  logic [2:0] bit_sel,
  input  logic [7:0] test_byte,
  input  logic [7:0] cmp_byte,
  output logic       is_branch,
  output logic       is_skip,
  output logic       cond_hit
);

  logic status_bit;
  logic tested_bit;
  logic lt_flag;

  assign status_bit = status[bit_sel];
  assign tested_bit = test_byte[bit_sel];
  assign lt_flag    = signed_lt(status);

  always_comb begin
    is_branch = 1'b0;
    is_skip   = 1'b0;
    cond_hit  = 1'b0;
    case (op_kind)
      OP_BR_BSET: begin is_branch = 1'b1; cond_hit = status_bit;         end
      OP_BR_BCLR: begin is_branch = 1'b1; cond_hit = !status_bit;        end
      OP_BR_SGE:  begin is_branch = 1'b1; cond_hit = !lt_flag;           end
      OP_BR_SLT:  begin is_branch = 1'b1; cond_hit = lt_flag;            end
      OP_BR_USH:  begin is_branch = 1'b1; cond_hit = !status[ST_CARRY];  end
      OP_BR_ULO:  begin is_branch = 1'b1; cond_hit = status[ST_CARRY];   end
      OP_SK_EQ:   begin is_skip   = 1'b1; cond_hit = (test_byte == cmp_byte); end
      OP_SK_BCLR: begin is_skip   = 1'b1; cond_hit = !tested_bit;        end
      OP_SK_BSET: begin is_skip   = 1'b1; cond_hit = tested_bit;         end
      default:    ;
    endcase
  end

endmodule

// File: rtl/flow_pc_calc.sv
module flow_pc_calc
  import flowctl_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  next_sel_e        sel,
  output logic [PC_W-1:0]  pc_next
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] rel_target;
  logic [PC_W-1:0] seq_target;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate

  assign rel_target = pc + off_ext + PC_W'(1);
  assign seq_target = pc + PC_W'(seq_step(sel));
  assign pc_next    = (sel == NX_REL) ? rel_target : seq_target;

endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc
  import flowctl_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [7:0]       status,
  input  logic [3:0]       op_kind,
  input  logic [OFF_W-1:0] rel_off,
  input  logic [2:0]       bit_sel,
  input  logic [7:0]       test_byte,
  input  logic [7:0]       cmp_byte,
  input  logic             next_two_word,
  output logic [PC_W-1:0]  nxt_pc,
  output logic             taken,
  output logic [1:0]       cycles
);

  logic            is_branch_w;
  logic            is_skip_w;
  logic            hit_w;
  next_sel_e       sel_w;
  logic [PC_W-1:0] pc_next_w;

  flow_cond_eval u_cond (
    .op_kind   (op_kind),
    .status    (status),
    .bit_sel   (bit_sel),
    .test_byte (test_byte),
    .cmp_byte  (cmp_byte),
    .is_branch (is_branch_w),
    .is_skip   (is_skip_w),
    .cond_hit  (hit_w)
  );

  always_comb begin
    if (is_branch_w && hit_w)     sel_w = NX_REL;
    else if (is_skip_w && hit_w)  sel_w = next_two_word ? NX_SKIP2 : NX_SKIP1;
    else                          sel_w = NX_SEQ;
  end

  flow_pc_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
    .pc      (cur_pc),
    .off     (rel_off),
    .sel     (sel_w),
    .pc_next (pc_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_pc <= '0;
      taken  <= 1'b0;
      cycles <= 2'd0;
    end else begin
      nxt_pc <= pc_next_w;
      taken  <= (sel_w != NX_SEQ);
      cycles <= cost_of(sel_w);
    end
  end

  // observation registers used only by the assertions below
  logic            live_q;
  logic            skip_q;
  logic [PC_W-1:0] pc_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q    <= 1'b0;
      skip_q    <= 1'b0;
      pc_seen_q <= '0;
    end else begin
      live_q    <= 1'b1;
      skip_q    <= is_skip_w;
      pc_seen_q <= cur_pc;
    end
  end

  // R5 R8 R9
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !taken) |-> (cycles == 2'd1 && nxt_pc == pc_seen_q + PC_W'(1)));

  // R5 R8
  taken_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && taken) |-> (cycles == 2'd2 || cycles == 2'd3));

  // R8
  skip_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cycles == 2'd3) |-> (taken && skip_q && nxt_pc == pc_seen_q + PC_W'(3)));

  // R8
  skip_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && taken && skip_q && cycles == 2'd2) |-> (nxt_pc == pc_seen_q + PC_W'(2)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (nxt_pc == '0 && !taken && cycles == 2'd0));

endmodule

// File: tb/flow_next_pc_tb.sv
`timescale 1ns/1ps
module flow_next_pc_tb;

  localparam int PW = 12;
  localparam int OW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cur_pc = '0;
  logic [7:0]    status = '0;
  logic [3:0]    op_kind = '0;
  logic [OW-1:0] rel_off = '0;
  logic [2:0]    bit_sel = '0;
  logic [7:0]    test_byte = '0;
  logic [7:0]    cmp_byte = '0;
  logic          next_two_word = 1'b0;
  logic [PW-1:0] nxt_pc;
  logic          taken;
  logic [1:0]    cycles;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  flow_next_pc #(.PC_W(PW), .OFF_W(OW)) u_dut (
    .clk, .rst_n, .cur_pc, .status, .op_kind, .rel_off, .bit_sel,
    .test_byte, .cmp_byte, .next_two_word, .nxt_pc, .taken, .cycles
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic check3(input string tag, input logic [PW-1:0] ep,
                        input logic et, input logic [1:0] ec);
    n_checks++;
    if (nxt_pc !== ep || taken !== et || cycles !== ec) begin
      n_fail++;
      $display("FAIL %s: op=%0d st=%h bs=%0d pc=%h off=%h actual pc=%h t=%b c=%0d expected pc=%h t=%b c=%0d",
               tag, op_kind, status, bit_sel, cur_pc, rel_off,
               nxt_pc, taken, cycles, ep, et, ec);
    end
  endtask

  // bench model of the whole decision, written from the requirements
  task automatic model(output logic [PW-1:0] ep, output logic et,
                       output logic [1:0] ec, output string tag);
    int  o, k;
    logic hit, br, sk;
    k  = int'(op_kind);
    br = (k <= 5);
    sk = (k >= 6 && k <= 8);
    case (k)
      0: hit = status[bit_sel];
      1: hit = !status[bit_sel];
      2: hit = (status[2] == status[3]);
      3: hit = (status[2] != status[3]);
      4: hit = !status[0];
      5: hit = status[0];
      6: hit = (test_byte == cmp_byte);
      7: hit = !test_byte[bit_sel];
      8: hit = test_byte[bit_sel];
      default: hit = 1'b0;
    endcase
    if (k <= 1) tag = "R2/R5";
    else if (k <= 3) tag = "R3/R5";
    else if (k <= 5) tag = "R4/R5";
    else if (k == 6) tag = "R6/R8";
    else if (k <= 8) tag = "R7/R8";
    else tag = "R9";
    o = (int'(rel_off) >= 64) ? int'(rel_off) - 128 : int'(rel_off);
    if (br && hit) begin
      ep = PW'((int'(cur_pc) + o + 1 + 4096) % 4096); et = 1; ec = 2;
    end else if (sk && hit) begin
      ep = PW'((int'(cur_pc) + (next_two_word ? 3 : 2)) % 4096);
      et = 1; ec = next_two_word ? 2'd3 : 2'd2;
    end else begin
      ep = PW'((int'(cur_pc) + 1) % 4096); et = 0; ec = 1;
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  logic [PW-1:0] ep;
  logic          et;
  logic [1:0]    ec;
  string         tag;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check3("R1", '0, 1'b0, 2'd0);
    rst_n = 1'b1;

    // sweep: every op code x status byte x bit index
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 256; s++) begin
        for (int b = 0; b < 8; b++) begin
          step_lfsr();
          op_kind       = 4'(k);
          status        = 8'(s);
          bit_sel       = 3'(b);
          cur_pc        = lfsr[PW-1:0];
          rel_off       = lfsr[15:9];
          test_byte     = 8'(s) ^ {lfsr[7:1], 1'b0};
          cmp_byte      = s[0] ? test_byte : test_byte ^ 8'h5A;
          next_two_word = lfsr[3] ^ s[1];
          model(ep, et, ec, tag);
          @(negedge clk);
          check3(tag, ep, et, ec);
        end
      end
    end

    // R5: relative target wraps past the top of the PC range
    op_kind = 4'd4; status = 8'h00; cur_pc = 12'hFFF; rel_off = 7'd5;
    @(negedge clk);
    check3("R5 wrap up", 12'h005, 1'b1, 2'd2);

    // R5: most negative offset from PC 0 wraps below zero
    op_kind = 4'd5; status = 8'h01; cur_pc = 12'h000; rel_off = 7'h40;
    @(negedge clk);
    check3("R5 wrap down", 12'hFC1, 1'b1, 2'd2);

    // R8: two-word skip wraps at the top of the PC range
    op_kind = 4'd6; test_byte = 8'h3C; cmp_byte = 8'h3C;
    cur_pc = 12'hFFE; next_two_word = 1'b1;
    @(negedge clk);
    check3("R8 wrap", 12'h001, 1'b1, 2'd3);

    // R10: new inputs do not reach the outputs before the next edge
    op_kind = 4'd9; cur_pc = 12'h100;
    #5;
    check3("R10 hold", 12'h001, 1'b1, 2'd3);
    @(negedge clk);
    check3("R10 update", 12'h101, 1'b0, 2'd1);

    // R9: undefined code ignores an all-set status and a large offset
    op_kind = 4'd15; status = 8'hFF; rel_off = 7'h3F; cur_pc = 12'h7FF;
    @(negedge clk);
    check3("R9", 12'h800, 1'b0, 2'd1);

    // R1: reset asserted mid-run clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check3("R1 again", '0, 1'b0, 2'd0);

    finish_run();
  end

endmodule